// File: doc/BRIEF.md
# Descriptor Ring Pipe Engine

One DMA pipe that works through a circular ring of 8-byte descriptors kept in system memory. Software fills ring slots and then publishes the byte offset just past the last valid slot. From its current offset, the engine reads one descriptor at a time through a single-beat memory read port. For each descriptor it presents the buffer address and byte count on a valid/ready transfer handshake. The current offset then advances by 8 bytes and wraps to zero at the programmed ring size.

Software can pause processing, enable or disable the pipe, reset every pipe register with a pulse, and read the current offset back. Flags inside each descriptor decide which completion events are latched in a status register. That status register drives one level interrupt through a per-bit enable mask.

Top module: `ring_pipe_engine`

## Requirements
- R1: After the reset input is released, every readable register reads 0, `mem_req`, `xfer_valid` and `irq` are 0, and the current offset is 0.
- R2: When the pipe is enabled (control bit 1), not paused, idle, and the current offset differs from the event offset (word 8), the engine raises `mem_req` with `mem_addr` = ring base (word 6, low 3 bits forced to 0) + current offset. The request stays up with a stable address until `mem_valid`.
- R3: A fetched 64-bit descriptor is split as bits 31:0 buffer address, bits 47:32 byte count and bits 63:48 flags. `xfer_valid` presents that address and count, held stable until `xfer_ready`. `xfer_to_mem` follows control bit 3.
- R4: Each completed descriptor advances the current offset (word 9) by 8. If the result is at or beyond the ring size (word 7), the offset becomes 0.
- R5: A descriptor with a byte count of 0 completes without any transfer handshake.
- R6: Writing 1 to bit 0 of word 2 stops new fetches. Writing 0 resumes from the unchanged current offset.
- R7: With control bit 1 clear, no descriptor is fetched.
- R8: Status (word 3) bit 0 sets when a descriptor with flag bit 15 completes, and bit 5 sets when one with flag bit 14 completes. Flag bit 13 sets no status bit.
- R9: Status bit 3 is set while the pipe is enabled, not paused, idle, and its current offset equals the event offset.
- R10: Writing a pattern to word 4 clears those status bits (a same-cycle set wins). `irq` is the OR of status bits ANDed with the enable mask (word 5, bits 5:0).
- R11: Writing 1 to bit 0 of word 1 returns all pipe registers, the status bits and the current offset to 0 and abandons any descriptor in progress. Until 0 is written there, other register writes are ignored and nothing is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_valid | input | 1 | Read data valid, one cycle |
| mem_data | input | 64 | Descriptor read data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_len | output | 16 | Transfer byte count |
| xfer_to_mem | output | 1 | Transfer direction, 1 = peripheral to memory |
| xfer_ready | input | 1 | Transfer accepted |
| irq | output | 1 | Pipe interrupt |

## Verification
The hold properties on `mem_req` and the transfer handshake assume two things. First, the ring base is not rewritten while a fetch is outstanding. Second, a pipe-reset write is the only event that may abandon a request. The stimulus follows both rules: it programs base and size only while the pipe is idle or held in pipe reset, and it answers each read after a fixed latency with a single-cycle `mem_valid`. Event offsets are always multiples of 8 and lie below the ring size, so the current offset can actually reach them.

// File: rtl/ring_pipe_engine.sv
module ring_pipe_engine #(
  parameter int OFS_W = 16,
  parameter int RA_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_valid,
  input  logic [63:0]     mem_data,
  output logic            xfer_valid,
  output logic [31:0]     xfer_addr,
  output logic [15:0]     xfer_len,
  output logic            xfer_to_mem,
  input  logic            xfer_ready,
  output logic            irq
);
  localparam int DESC_B = 8;
  localparam int ST_W   = 6;
  localparam logic [RA_W-1:0] A_CTRL = 0, A_RST = 1, A_HALT = 2, A_STAT = 3, A_CLR = 4,
                              A_IEN = 5, A_BASE = 6, A_SIZE = 7, A_EVT = 8, A_CUR = 9;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} st_t;

  st_t              state;
  logic [31:0]      ctrl_q, base_q;
  logic             halt_q, prst_q;
  logic [ST_W-1:0]  stat_q, ien_q, set_m, clr_m;
  logic [OFS_W-1:0] size_q, evt_q, cur_q, nxt_ofs;
  logic [OFS_W:0]   inc_ofs;
  logic [47:0]      desc_q;
  logic [1:0]       flg_q, done_flg;
  logic             run, done, rst_hit;
  wire              unused_flag_bits = ^mem_data[61:48];

  assign run      = ctrl_q[1] & ~halt_q;
  assign inc_ofs  = {1'b0, cur_q} + DESC_B[OFS_W:0];
  assign nxt_ofs  = (inc_ofs >= {1'b0, size_q}) ? '0 : inc_ofs[OFS_W-1:0];
  assign rst_hit  = reg_wr && reg_addr == A_RST && reg_wdata[0];

  assign mem_req     = state == S_FETCH;
  assign mem_addr    = base_q + {{(32-OFS_W){1'b0}}, cur_q};
  assign xfer_valid  = state == S_XFER;
  assign xfer_addr   = desc_q[31:0];
  assign xfer_len    = desc_q[47:32];
  assign xfer_to_mem = ctrl_q[3];
  assign irq         = |(stat_q & ien_q);

  assign done     = (state == S_FETCH && mem_valid && mem_data[47:32] == 16'd0) ||
                    (state == S_XFER && xfer_ready);
  assign done_flg = (state == S_FETCH) ? mem_data[63:62] : flg_q;

  always_comb begin
    set_m = '0;
    if (done) begin
      set_m[0] = done_flg[1];
      set_m[5] = done_flg[0];
    end
    if (state == S_IDLE && run && cur_q == evt_q) set_m[3] = 1'b1;
    clr_m = (reg_wr && reg_addr == A_CLR) ? reg_wdata[ST_W-1:0] : '0;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_RST:   reg_rdata = {31'd0, prst_q};
      A_HALT:  reg_rdata = {31'd0, halt_q};
      A_STAT:  reg_rdata = {{(32-ST_W){1'b0}}, stat_q};
      A_IEN:   reg_rdata = {{(32-ST_W){1'b0}}, ien_q};
      A_BASE:  reg_rdata = base_q;
      A_SIZE:  reg_rdata = {{(32-OFS_W){1'b0}}, size_q};
      A_EVT:   reg_rdata = {{(32-OFS_W){1'b0}}, evt_q};
      A_CUR:   reg_rdata = {{(32-OFS_W){1'b0}}, cur_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || rst_hit) begin
      state  <= S_IDLE;
      ctrl_q <= '0;
      base_q <= '0;
      halt_q <= 1'b0;
      prst_q <= rst_n;
      stat_q <= '0;
      ien_q  <= '0;
      size_q <= '0;
      evt_q  <= '0;
      cur_q  <= '0;
      desc_q <= '0;
      flg_q  <= '0;
    end else if (prst_q) begin
      if (reg_wr && reg_addr == A_RST) prst_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_m) | set_m;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= reg_wdata & 32'h0000_002A;
          A_HALT: halt_q <= reg_wdata[0];
          A_IEN:  ien_q  <= reg_wdata[ST_W-1:0];
          A_BASE: base_q <= {reg_wdata[31:3], 3'b000};
          A_SIZE: size_q <= reg_wdata[OFS_W-1:0];
          A_EVT:  evt_q  <= reg_wdata[OFS_W-1:0];
          default: ;
        endcase
      end
      if (done) cur_q <= nxt_ofs;
      case (state)
        S_IDLE:  if (run && cur_q != evt_q) state <= S_FETCH;
        S_FETCH: if (mem_valid) begin
                   desc_q <= mem_data[47:0];
                   flg_q  <= mem_data[63:62];
                   state  <= (mem_data[47:32] == 16'd0) ? S_IDLE : S_XFER;
                 end
        S_XFER:  if (xfer_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_pipe_engine_chk.sv
module ring_pipe_engine_chk #(
  parameter int RA_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr,
  input logic            reg_wdata0,
  input logic            mem_req,
  input logic [31:0]     mem_addr,
  input logic            mem_valid,
  input logic            xfer_valid,
  input logic [31:0]     xfer_addr,
  input logic [15:0]     xfer_len,
  input logic            xfer_ready,
  input logic            halt_q,
  input logic            prst_q
);
  logic kill;
  assign kill = reg_wr && reg_addr == RA_W'(1) && reg_wdata0;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid && !kill |=> mem_req && $stable(mem_addr));

  // R3
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready && !kill |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

  // R3
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_valid));

  // R6
  halt_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !mem_req |=> !mem_req);

  // R11
  prst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prst_q |-> !mem_req && !xfer_valid);
endmodule

bind ring_pipe_engine ring_pipe_engine_chk #(.RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata0(reg_wdata[0]),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_ready(xfer_ready),
  .halt_q(halt_q), .prst_q(prst_q));

// File: tb/ring_pipe_engine_bench.sv
`timescale 1ns/1ps
module ring_pipe_engine_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_valid = 0, xfer_valid, xfer_ready = 0, xfer_to_mem, irq;
  logic [31:0] mem_addr, xfer_addr;
  logic [63:0] mem_data = 0;
  logic [15:0] xfer_len;

  always #2.5 clk = ~clk;

  ring_pipe_engine u_ring_pipe_engine (.*);

  int total = 0, bad = 0, cyc = 0, hs_cnt = 0, mcnt = 0, xcnt = 0;
  logic [63:0] mem [0:63];

  // reference model state
  int m_ctrl, m_halt, m_prst, m_stat, m_ien, m_base, m_size, m_evt, m_cur, m_state;
  logic [63:0] m_d;
  int ns, ncur, setm, clrm;
  logic mdone;
  logic [63:0] nd;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0: return m_ctrl; 1: return m_prst; 2: return m_halt; 3: return m_stat;
      5: return m_ien;  6: return m_base; 7: return m_size; 8: return m_evt;
      9: return m_cur;  default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || (reg_wr && reg_addr == 1 && reg_wdata[0])) begin
      m_ctrl = 0; m_halt = 0; m_stat = 0; m_ien = 0; m_base = 0; m_size = 0;
      m_evt = 0; m_cur = 0; m_state = 0; m_d = 0; m_prst = rst_n ? 1 : 0;
    end else if (m_prst != 0) begin
      if (reg_wr && reg_addr == 1) m_prst = 0;
    end else begin
      ns = m_state; nd = m_d; ncur = m_cur; setm = 0; mdone = 0;
      if (m_state == 0) begin
        if (m_ctrl[1] && m_halt == 0) begin
          if (m_cur != m_evt) ns = 1; else setm = 8;
        end
      end else if (m_state == 1 && mem_valid) begin
        nd = mem_data;
        if (mem_data[47:32] == 0) begin mdone = 1; ns = 0; end else ns = 2;
      end else if (m_state == 2 && xfer_ready) begin
        mdone = 1; ns = 0;
      end
      if (mdone) begin
        if (nd[63]) setm = setm | 1;
        if (nd[62]) setm = setm | 32;
        ncur = (m_cur + 8 >= m_size) ? 0 : m_cur + 8;
      end
      clrm = (reg_wr && reg_addr == 4) ? int'(reg_wdata[5:0]) : 0;
      m_stat = (m_stat & ~clrm) | setm;
      if (reg_wr) case (reg_addr)
        0: m_ctrl = reg_wdata & 32'h2A;
        2: m_halt = reg_wdata[0];
        5: m_ien  = reg_wdata[5:0];
        6: m_base = reg_wdata & 32'hFFFF_FFF8;
        7: m_size = reg_wdata[15:0];
        8: m_evt  = reg_wdata[15:0];
        default: ;
      endcase
      m_state = ns; m_d = nd; m_cur = ncur;
    end
  end

  // memory and transfer responders
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 0; xfer_ready = 0; mcnt = 0; xcnt = 0;
    end else begin
      if (mem_valid) mem_valid = 0;
      else if (mem_req) begin
        mcnt++;
        if (mcnt >= 2) begin mcnt = 0; mem_valid = 1; mem_data = mem[mem_addr[8:3]]; end
      end
      if (xfer_ready) xfer_ready = 0;
      else if (xfer_valid) begin
        xcnt++;
        if (xcnt > int'(xfer_len[1:0])) begin xcnt = 0; xfer_ready = 1; hs_cnt++; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(mem_req == (m_state == 1), "R2 mem_req", mem_req, m_state == 1);
      if (m_state == 1) chk(mem_addr == m_base + m_cur, "R2 mem_addr", mem_addr, m_base + m_cur);
      chk(xfer_valid == (m_state == 2), "R3 xfer_valid", xfer_valid, m_state == 2);
      if (m_state == 2) begin
        chk(xfer_addr == m_d[31:0], "R3 xfer_addr", xfer_addr, m_d[31:0]);
        chk(xfer_len == m_d[47:32], "R3 xfer_len", xfer_len, m_d[47:32]);
      end
      chk(xfer_to_mem == m_ctrl[3], "R3 direction", xfer_to_mem, m_ctrl[3]);
      chk(irq == ((m_stat & m_ien) != 0), "R10 irq", irq, (m_stat & m_ien) != 0);
      chk(reg_rdata == m_read(int'(reg_addr)), "R4 readback", reg_rdata, m_read(int'(reg_addr)));
    end
  end

  always @(posedge clk) if (cyc == 150000) begin
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = a[3:0]; #2; v = reg_rdata;
  endtask

  task automatic wait_cur(input int target);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (m_cur == target && m_state == 0) break;
    end
  endtask

  function automatic logic [63:0] dsc(input int a, input int len, input int fl);
    return {fl[15:0], len[15:0], a[31:0]};
  endfunction

  int v;
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[32] = dsc(32'hA000_0000, 16, 16'h8000);
    mem[33] = dsc(32'hA000_1000, 0, 0);
    mem[34] = dsc(32'hA000_2000, 5, 16'h4000);
    mem[35] = dsc(32'hA000_3000, 4, 16'h2000);
    mem[36] = dsc(32'hB000_0000, 2, 0);
    mem[37] = dsc(32'hB000_0100, 3, 0);
    mem[38] = dsc(32'hB000_0200, 0, 0);
    mem[39] = dsc(32'hB000_0300, 7, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(a, v); chk(v == 0, "R1 register default", v, 0);
    end
    chk(!mem_req && !xfer_valid && !irq, "R1 outputs idle", {mem_req, xfer_valid, irq}, 0);

    wr(6, 32'h0000_0105); wr(7, 64); wr(5, 6'h3F);
    rd(6, v); chk(v == 32'h100, "R2 base aligned", v, 32'h100);
    rd(3, v); chk(v == 0, "R9 no empty when disabled", v, 0);
    wr(0, 32'h22);
    repeat (2) @(negedge clk);
    rd(3, v); chk(v == 8, "R9 empty status", v, 8);
    chk(irq == 1, "R10 irq from status", irq, 1);
    wr(0, 0); wr(4, 8);
    rd(3, v); chk(v == 0, "R10 clear", v, 0);
    chk(irq == 0, "R10 irq low", irq, 0);

    wr(0, 32'h22); wr(8, 8); wait_cur(8);
    rd(9, v); chk(v == 8, "R4 advance", v, 8);
    rd(3, v); chk((v & 1) == 1, "R8 interrupt flag", v & 1, 1);
    chk(hs_cnt == 1, "R3 one transfer", hs_cnt, 1);
    wr(4, 9);
    rd(3, v); chk(v == 8, "R10 clear then empty resets", v, 8);

    wr(8, 32); wait_cur(32);
    rd(9, v); chk(v == 32, "R4 offset 32", v, 32);
    rd(3, v); chk(v == 32'h28, "R8 end-of-transfer only, block mark ignored", v, 32'h28);
    chk(hs_cnt == 3, "R5 zero count skips handshake", hs_cnt, 3);

    wr(8, 0); wait_cur(0);
    rd(9, v); chk(v == 0, "R4 wrap to zero", v, 0);
    chk(hs_cnt == 6, "R5 wrap transfers", hs_cnt, 6);

    wr(2, 1); wr(8, 16);
    repeat (30) @(negedge clk);
    rd(9, v); chk(v == 0, "R6 halted offset", v, 0);
    chk(hs_cnt == 6, "R6 no transfer while halted", hs_cnt, 6);
    wr(2, 0); wait_cur(16);
    rd(9, v); chk(v == 16, "R6 resumed", v, 16);

    wr(0, 32'h0A); wr(8, 24);
    for (int i = 0; i < 100 && !xfer_valid; i++) @(negedge clk);
    chk(xfer_valid && xfer_to_mem && xfer_len == 5 && xfer_addr == 32'hA000_2000,
        "R3 fields and direction", {xfer_to_mem, xfer_len}, {1'b1, 16'd5});
    wait_cur(24);

    wr(8, 48); repeat (3) @(negedge clk);
    wr(1, 1);
    rd(9, v); chk(v == 0, "R11 offset cleared", v, 0);
    rd(0, v); chk(v == 0, "R11 control cleared", v, 0);
    wr(0, 32'h2A);
    rd(0, v); chk(v == 0, "R11 write ignored", v, 0);
    chk(!mem_req && !xfer_valid, "R11 no activity", {mem_req, xfer_valid}, 0);
    wr(1, 0);
    rd(1, v); chk(v == 0, "R11 released", v, 0);

    wr(6, 32'h100); wr(7, 64); wr(8, 8); wr(0, 32'h20);
    repeat (20) @(negedge clk);
    rd(9, v); chk(v == 0, "R7 disabled no fetch", v, 0);
    wr(0, 32'h22); wait_cur(8);
    rd(9, v); chk(v == 8, "R7 enabled fetch", v, 8);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule